// File: doc/BRIEF.md
# Multiplexed ADC Conversion Controller

This block is the digital sequencer of an eight-channel, 12-bit sampling acquisition unit. It keeps the selected input channel in a small register that loads from a 3-bit address on a falling edge of an address-load strobe. It starts a conversion when the read/convert line falls while the enable input is high. Each conversion is a fixed acquisition window followed by a fixed conversion window, both counted in clock cycles derived from the clock frequency. A busy flag stays high across both windows.

At the end of acquisition the block sends a one-cycle start pulse to the external quantiser. It takes the first one-cycle done strobe that comes back with the 12-bit result during the conversion window. When the window has elapsed and a result is held, the result moves into the output register and the busy flag drops. The output register drives a tri-state 12-bit bus only for a read, which needs enable high, the read/convert line high and the busy flag low. With a 10 MHz clock the windows are 19 and 81 cycles, which gives one sample every 10 µs.

Top module: `daq_conv_ctrl`

## Requirements
- R1: On a clock where `addr_load_i` was sampled 1 at the previous edge and is 0 now, `chan_sel_o` takes the value of `addr_i` from the next cycle on. The code is straight binary: 000 selects channel 0 and 111 selects channel 7.
- R2: Without such a falling edge, `chan_sel_o` keeps its value whatever `addr_i` does, even while `addr_load_i` stays low.
- R3: If `en_i` is 1 and `rd_nconv_i` falls from 1 to 0 (sampled on successive edges) while `busy_o` is 0, `busy_o` is 1 in the next cycle. A falling `rd_nconv_i` with `en_i` at 0 starts nothing.
- R4: `core_start_o` is high for exactly one cycle. That cycle is the busy cycle at index ACQ_CYC, counted from 0 at the first busy cycle, so it comes after ACQ_CYC = 19 acquisition cycles at the default 10 MHz.
- R5: If a result has been taken by the last conversion cycle (busy index ACQ_CYC+CONV_CYC-1 = 99), `busy_o` is high for exactly ACQ_CYC+CONV_CYC = 100 cycles. Otherwise `busy_o` falls in the cycle after the done strobe.
- R6: The output register loads the taken result only when the conversion ends. The value is 12-bit straight binary, with bit 11 the MSB and bit 0 the LSB of `data_o`.
- R7: `data_oe_o` is 1, and `data_o` carries the output register, only while `en_i`=1, `rd_nconv_i`=1 and `busy_o`=0. Otherwise `data_o` is high impedance, including during a read that overlaps a conversion.
- R8: A start request while `busy_o` is 1 is ignored. The conversion in progress keeps its timing.
- R9: A `core_done_i` strobe outside the conversion window (when idle, or during acquisition) is ignored. It changes neither the output register nor the busy timing.
- R10: Reset (`rst_ni` low) selects channel 0, clears `busy_o` and the output register, and releases the bus.
- R11: Only the first done strobe of a conversion window supplies the result. Later strobes in the same window are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable for both start and read |
| rd_nconv_i | input | 1 | High: read; a falling edge requests a conversion |
| addr_load_i | input | 1 | Channel address load strobe, acts on its falling edge |
| addr_i | input | 3 | Channel address |
| core_done_i | input | 1 | One-cycle done strobe from the quantiser |
| core_data_i | input | 12 | Result word, valid with core_done_i |
| chan_sel_o | output | 3 | Selected channel to the analog multiplexer |
| core_start_o | output | 1 | One-cycle start pulse to the quantiser |
| busy_o | output | 1 | High from start of acquisition to end of conversion |
| data_oe_o | output | 1 | Bus drive enable, a copy of the tri-state control |
| data_o | output | 12 | Tri-state result bus |

## Verification
The done strobe can arrive in the very cycle in which the conversion window elapses. The block must then take the result, load the output register and drop busy together. The bench provokes this by placing the strobe exactly CONV_CYC-1 cycles after the start pulse, and also one cycle earlier and several cycles later. A behavioural model judges each case on every clock by the length of the busy period and by the value a following read returns. The same treatment covers a start request or a read request that overlaps a running conversion, which must leave both the timing and the bus untouched.

// File: rtl/daq_pkg.sv
package daq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACQ  = 2'd1,
    PH_CONV = 2'd2
  } phase_e;

  // ceiling of hz*ns/1e9
  function automatic int unsigned ns_to_cyc(longint unsigned hz, longint unsigned ns);
    return 32'((hz * ns + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction
endpackage

// File: rtl/daq_edge_det.sv
module daq_edge_det #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    // reset to 0: a line held low through reset gives no false edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[i] <= 1'b0;
      else         prev_q[i] <= sig_i[i];
    end
    assign fall_o[i] = prev_q[i] & ~sig_i[i];
  end
endmodule

// File: rtl/daq_chan_reg.sv
module daq_chan_reg #(
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] chan_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     chan_o <= '0;
    else if (load_i) chan_o <= addr_i;
  end
endmodule

// File: rtl/daq_seq.sv
module daq_seq
  import daq_pkg::*;
#(
  parameter int ACQ_CYC  = 19,
  parameter int CONV_CYC = 81
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic done_i,
  output logic busy_o,
  output logic core_start_o,
  output logic take_o,
  output logic finish_o
);
  localparam int MAX_CYC = (ACQ_CYC > CONV_CYC) ? ACQ_CYC : CONV_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] ACQ_LAST  = CNT_W'(ACQ_CYC - 1);
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYC - 1);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             got_q;
  logic             elapsed;

  assign busy_o       = (phase_q != PH_IDLE);
  assign core_start_o = (phase_q == PH_CONV) && (cnt_q == '0);
  assign take_o       = (phase_q == PH_CONV) && done_i && !got_q;
  assign elapsed      = (phase_q == PH_CONV) && (cnt_q == CONV_LAST);
  assign finish_o     = elapsed && (got_q || done_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      got_q   <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            phase_q <= PH_ACQ;
            cnt_q   <= '0;
            got_q   <= 1'b0;
          end
        end
        PH_ACQ: begin
          if (cnt_q == ACQ_LAST) begin
            phase_q <= PH_CONV;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_CONV: begin
          if (take_o) got_q <= 1'b1;
          if (finish_o) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            got_q   <= 1'b0;
          end else if (!elapsed) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/daq_out_reg.sv
module daq_out_reg #(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              finish_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rd_en_i,
  output logic              oe_o,
  output wire  [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      out_q  <= '0;
    end else begin
      if (take_i) hold_q <= data_i;
      // result arriving in the final cycle bypasses the holding register
      if (finish_i) out_q <= take_i ? data_i : hold_q;
    end
  end

  assign oe_o   = rd_en_i;
  assign data_o = oe_o ? out_q : {DATA_W{1'bz}};
endmodule

// File: rtl/daq_conv_ctrl.sv
module daq_conv_ctrl
  import daq_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 10_000_000,
  parameter int unsigned ACQ_NS  = 1900,
  parameter int unsigned CONV_NS = 8100,
  parameter int          CH_N    = 8,
  parameter int          DATA_W  = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic                     rd_nconv_i,
  input  logic                     addr_load_i,
  input  logic [$clog2(CH_N)-1:0]  addr_i,
  input  logic                     core_done_i,
  input  logic [DATA_W-1:0]        core_data_i,
  output logic [$clog2(CH_N)-1:0]  chan_sel_o,
  output logic                     core_start_o,
  output logic                     busy_o,
  output logic                     data_oe_o,
  output wire  [DATA_W-1:0]        data_o
);
  localparam int ADDR_W   = $clog2(CH_N);
  localparam int ACQ_CYC  = int'(ns_to_cyc(longint'(CLK_HZ), longint'(ACQ_NS)));
  localparam int CONV_CYC = int'(ns_to_cyc(longint'(CLK_HZ), longint'(CONV_NS)));

  logic [1:0] falls;
  logic       start_req;
  logic       take;
  logic       finish;

  daq_edge_det #(.W(2)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  ({rd_nconv_i, addr_load_i}),
    .fall_o (falls)
  );

  daq_chan_reg #(.ADDR_W(ADDR_W)) u_chan (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (falls[0]),
    .addr_i (addr_i),
    .chan_o (chan_sel_o)
  );

  assign start_req = en_i && falls[1];

  daq_seq #(.ACQ_CYC(ACQ_CYC), .CONV_CYC(CONV_CYC)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_req),
    .done_i       (core_done_i),
    .busy_o       (busy_o),
    .core_start_o (core_start_o),
    .take_o       (take),
    .finish_o     (finish)
  );

  daq_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .take_i   (take),
    .finish_i (finish),
    .data_i   (core_data_i),
    .rd_en_i  (en_i && rd_nconv_i && !busy_o),
    .oe_o     (data_oe_o),
    .data_o   (data_o)
  );
endmodule

// File: rtl/daq_conv_ctrl_chk.sv
module daq_conv_ctrl_chk #(
  parameter int TOTAL_CYC = 100,
  parameter int ADDR_W    = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              rd_nconv_i,
  input logic              addr_load_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] chan_sel_o,
  input logic              core_start_o,
  input logic              busy_o,
  input logic              data_oe_o
);
  logic armed_q;
  int   busy_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q    <= 1'b0;
      busy_cnt_q <= 0;
    end else begin
      armed_q    <= 1'b1;
      busy_cnt_q <= busy_o ? busy_cnt_q + 1 : 0;
    end
  end

  // R1
  chan_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $fell(addr_load_i) |=> chan_sel_o == $past(addr_i));
  // R2
  chan_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && !$fell(addr_load_i) |=> $stable(chan_sel_o));
  // R3
  start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && !busy_o && en_i && $fell(rd_nconv_i) |=> busy_o);
  // R8
  idle_stays_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && !busy_o && !(en_i && $fell(rd_nconv_i)) |=> !busy_o);
  // R4
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_start_o |=> !core_start_o);
  // R4
  start_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_start_o |-> busy_o);
  // R5
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> busy_cnt_q >= TOTAL_CYC);
  // R7
  bus_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !data_oe_o);
endmodule

bind daq_conv_ctrl daq_conv_ctrl_chk #(
  .TOTAL_CYC (ACQ_CYC + CONV_CYC),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .rd_nconv_i   (rd_nconv_i),
  .addr_load_i  (addr_load_i),
  .addr_i       (addr_i),
  .chan_sel_o   (chan_sel_o),
  .core_start_o (core_start_o),
  .busy_o       (busy_o),
  .data_oe_o    (data_oe_o)
);

// File: tb/daq_conv_ctrl_bench.sv
module daq_conv_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ACQ  = 19;   // 1.9 us at 10 MHz
  localparam int CONV = 81;   // 8.1 us at 10 MHz

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, rdc = 1'b1, ld = 1'b1;
  logic [2:0]  addr = '0;
  logic        done = 1'b0;
  logic [11:0] din = '0;
  logic [2:0]  chan;
  logic        cstart, busy, oe;
  wire  [11:0] dbus;

  int    n_vec = 0, n_bad = 0, cyc = 0;
  string cur_req = "R10";

  daq_conv_ctrl u_daq_conv_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .rd_nconv_i(rdc),
    .addr_load_i(ld), .addr_i(addr), .core_done_i(done), .core_data_i(din),
    .chan_sel_o(chan), .core_start_o(cstart), .busy_o(busy),
    .data_oe_o(oe), .data_o(dbus)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model
  bit          m_busy, m_got, m_lp, m_rp;
  int          m_t;
  logic [2:0]  m_chan;
  logic [11:0] m_res, m_out;

  always @(posedge clk) begin
    bit st;
    st = en && !rdc && m_rp && !m_busy;
    if (!rst_n) begin
      m_busy = 0; m_got = 0; m_lp = 0; m_rp = 0; m_t = 0;
      m_chan = '0; m_res = '0; m_out = '0;
    end else begin
      if (m_lp && !ld) m_chan = addr;
      m_lp = ld;
      m_rp = rdc;
      if (m_busy) begin
        if (done && m_t >= ACQ && !m_got) begin m_got = 1; m_res = din; end
        if (m_t >= ACQ + CONV - 1 && m_got) begin m_busy = 0; m_out = m_res; end
        else m_t++;
      end else if (st) begin
        m_busy = 1; m_t = 0; m_got = 0;
      end
    end
  end

  task automatic chk(string sig, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", cur_req, sig, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit exp_oe;
    if (rst_n) begin
      exp_oe = en && rdc && !m_busy;
      chk("chan", int'(chan), int'(m_chan));
      chk("busy", int'(busy), int'(m_busy));
      chk("core_start", int'(cstart), int'(m_busy && m_t == ACQ));
      chk("oe", int'(oe), int'(exp_oe));
      if (exp_oe) chk("data", int'(dbus), int'(m_out));
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL %s watchdog act=hung exp=finished", cur_req);
      summary();
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wait_start();
    int g = 0;
    while (!cstart && g < 1000) begin @(negedge clk); g++; end
  endtask

  task automatic pulse_done(logic [11:0] v);
    din = v; done = 1'b1; step(); done = 1'b0;
  endtask

  // d: cycles after start pulse for the done strobe
  // d2: second strobe delay (0 = none), poke: start/read during busy, early: strobe in acquisition
  task automatic convert(int d, logic [11:0] v, int d2, logic [11:0] v2, bit poke, bit early);
    int g = 0;
    en = 1'b1; rdc = 1'b0; step();
    if (early) begin step(); pulse_done(12'hBAD); end
    if (poke) begin
      rdc = 1'b1; step(); step();      // read while busy: bus must stay off (R7)
      rdc = 1'b0; step();              // start while busy: ignored (R8)
      rdc = 1'b1; step();
    end
    wait_start();
    repeat (d) @(posedge clk);
    #1; pulse_done(v);
    if (d2 > d) begin
      repeat (d2 - d - 1) step();
      pulse_done(v2);
    end
    while (busy && g < 1000) begin @(negedge clk); g++; end
    step(); rdc = 1'b1; step(); step(); step();
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    // R10: reset state, read returns zero
    cur_req = "R10";
    step(); en = 1'b1; rdc = 1'b1; step(); step(); step();

    // R1: every channel code
    cur_req = "R1";
    for (int i = 0; i < 8; i++) begin
      addr = 3'(7 - i); ld = 1'b0; step(); ld = 1'b1; step();
    end

    // R2: address moves with no falling edge, and while held low
    cur_req = "R2";
    for (int i = 0; i < 5; i++) begin addr = 3'(i); step(); end
    addr = 3'd5; ld = 1'b0; step();
    for (int i = 0; i < 4; i++) begin addr = 3'(i + 1); step(); end
    ld = 1'b1; step();

    // R3: falling read/convert with enable low starts nothing
    cur_req = "R3";
    en = 1'b0; rdc = 1'b0; step(); step(); rdc = 1'b1; step(); en = 1'b1; step();

    // R4 R6: nominal conversion, early done
    cur_req = "R4";
    convert(10, 12'hA5C, 0, '0, 1'b0, 1'b0);
    // R5: done coincides with interval end, one before, and late
    cur_req = "R5";
    convert(CONV - 1, 12'h3C3, 0, '0, 1'b0, 1'b0);
    convert(CONV - 2, 12'h0F0, 0, '0, 1'b0, 1'b0);
    convert(CONV + 4, 12'hFFF, 0, '0, 1'b0, 1'b0);
    // R6: MSB only
    cur_req = "R6";
    convert(3, 12'h800, 0, '0, 1'b0, 1'b0);
    // R7 R8: read and start requests during a conversion
    cur_req = "R8";
    convert(20, 12'h155, 0, '0, 1'b1, 1'b0);
    // R9: strobe while idle, then strobe during acquisition
    cur_req = "R9";
    pulse_done(12'h123); step(); step();
    convert(15, 12'h2AA, 0, '0, 1'b0, 1'b1);
    // R11: two strobes in one conversion window
    cur_req = "R11";
    convert(5, 12'h001, 12, 12'h7FE, 1'b0, 1'b0);
    // R1 again: channel load during a conversion
    cur_req = "R1";
    en = 1'b1; rdc = 1'b0; step(); addr = 3'd6; ld = 1'b0; step(); ld = 1'b1; step();
    rdc = 1'b1; wait_start(); step(); pulse_done(12'h456);
    while (busy) @(negedge clk);
    step(); step();

    summary();
    $finish;
  end
endmodule